// File: doc/BRIEF.md
# Configurable Condition Comparator

This block is a purely combinational relation tester. It takes two operands of a configurable width, `lhs_b` and `rhs_a`, and a 3-bit condition selector, and returns one flag that is 1 when the selected relation holds and 0 otherwise. The relation is always read with `lhs_b` on the left: the flag for a less-than selector is true when `lhs_b` is below `rhs_a`. Some ordering selectors treat both operands as unsigned binary numbers. Others treat them as two's-complement signed values.

A typical use is as the branch or condition stage of a small datapath, or as the source of a status indicator. No part of the block is registered, so the flag follows its inputs within the same cycle. A build-time parameter chooses between two internal forms of the ordering logic. One derives the orderings from a borrow out of a subtraction. The other uses direct magnitude comparison. Both forms give identical results at the ports.

Top module: `cond_cmp`

## Requirements
- R1: Selector 3'b000 drives the flag to 1 exactly when `lhs_b` equals `rhs_a`.
- R2: Selector 3'b001 drives the flag to 1 exactly when `lhs_b` and `rhs_a` differ.
- R3: Selector 3'b010 drives the flag to 1 when `lhs_b` is below `rhs_a`, with both read as unsigned.
- R4: Selector 3'b011 drives the flag to 1 when `lhs_b` is above `rhs_a`, with both read as unsigned.
- R5: Selector 3'b100 drives the flag to 1 when `lhs_b` is below or equal to `rhs_a`, with both read as unsigned.
- R6: Selector 3'b101 drives the flag to 1 when `lhs_b` is below `rhs_a`, with both read as two's-complement signed.
- R7: Selector 3'b110 drives the flag to 1 when `lhs_b` is above `rhs_a`, with both read as signed.
- R8: Selector 3'b111 drives the flag to 1 when `lhs_b` is below or equal to `rhs_a`, with both read as signed.
- R9: The operand width is the parameter `WIDTH`, which defaults to 8. Both internal forms (`BORROW_FORM` 1 or 0) give the same flag for every input.
- R10: The signed extremes order correctly. With 8-bit operands, 8'h80 is below 8'h7F under the signed selectors and above it under the unsigned selectors.
- R11: The flag is combinational and settles in the same cycle that any input changes, with no clock or state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lhs_b | input | WIDTH | Left-hand operand of every relation |
| rhs_a | input | WIDTH | Right-hand operand of every relation |
| cond_sel | input | 3 | Relation selector (encodings in R1 to R8) |
| cond_true | output | 1 | 1 when the selected relation holds |

## Verification
The bench runs every operand pair under every selector. It does this for the default 8-bit build, which uses the borrow form, and for a 4-bit build that uses direct comparison. Pairs where the operands are equal separate the strict relations from the or-equal relations. Pairs whose sign bits differ are the only ones where the signed and unsigned results disagree, so they expose a wrong interpretation. The pair 8'h80 and 8'h7F is also checked on its own, in both operand orders, as the extreme case. Each check changes the inputs and samples one nanosecond later, which catches any behaviour that waits for a clock.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic [2:0] {
    CC_EQ  = 3'b000,
    CC_NE  = 3'b001,
    CC_ULT = 3'b010,
    CC_UGT = 3'b011,
    CC_ULE = 3'b100,
    CC_SLT = 3'b101,
    CC_SGT = 3'b110,
    CC_SLE = 3'b111
  } cond_code_e;
endpackage

// File: rtl/cmp_relations.sv
module cmp_relations #(
  parameter int WIDTH       = 8,
  parameter bit BORROW_FORM = 1'b1
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output logic             same,
  output logic             below_u,
  output logic             below_s
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] SIGN_MASK = {1'b1, {(WIDTH-1){1'b0}}};

  // Zero detect on the bitwise difference
  assign same = ~|(lhs ^ rhs);

  generate
    if (BORROW_FORM) begin : g_borrow
      logic [WIDTH:0] diff_u;
      logic [WIDTH:0] diff_s;
      // Unsigned: borrow out of lhs - rhs means lhs < rhs
      assign diff_u  = {1'b0, lhs} - {1'b0, rhs};
      // Signed: flipping the sign bit maps signed order onto unsigned order
      assign diff_s  = {1'b0, lhs ^ SIGN_MASK} - {1'b0, rhs ^ SIGN_MASK};
      assign below_u = diff_u[WIDTH];
      assign below_s = diff_s[WIDTH];
    end else begin : g_native
      assign below_u = lhs < rhs;
      assign below_s = $signed(lhs) < $signed(rhs);
    end
  endgenerate

  always_comb begin
    if (!$isunknown({lhs, rhs})) begin
      // R1 / R3: equal operands never order strictly
      p_eq_not_below_r3: assert (!(same && below_u));
      // R10: differing sign bits flip the signed order against the unsigned one
      if (lhs[MSB] != rhs[MSB])
        p_sign_split_r10: assert (below_s == !below_u);
      else
        p_sign_match_r6: assert (below_s == below_u);
    end
  end
endmodule

// File: rtl/cond_select.sv
module cond_select
  import cmp_pkg::*;
(
  input  cond_code_e code,
  input  logic       same,
  input  logic       below_u,
  input  logic       below_s,
  output logic       flag
);
  always_comb begin
    unique case (code)
      CC_EQ:   flag = same;
      CC_NE:   flag = !same;
      CC_ULT:  flag = below_u;
      CC_UGT:  flag = !below_u && !same;
      CC_ULE:  flag = below_u || same;
      CC_SLT:  flag = below_s;
      CC_SGT:  flag = !below_s && !same;
      CC_SLE:  flag = below_s || same;
      default: flag = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown({code, same, below_u, below_s})) begin
      // R4 / R5: strictly-above and at-most are complements
      if (code == CC_UGT)
        p_ugt_excl_r4: assert (!(flag && (below_u || same)));
      // R7: signed above excludes equality
      if (code == CC_SGT)
        p_sgt_excl_r7: assert (!(flag && same));
    end
  end
endmodule

// File: rtl/cond_cmp.sv
module cond_cmp
  import cmp_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter bit BORROW_FORM = 1'b1
) (
  input  logic [WIDTH-1:0] lhs_b,
  input  logic [WIDTH-1:0] rhs_a,
  input  logic [2:0]       cond_sel,
  output logic             cond_true
);
  logic same_w, below_u_w, below_s_w;
  cond_code_e code_w;

  assign code_w = cond_code_e'(cond_sel);

  cmp_relations #(.WIDTH(WIDTH), .BORROW_FORM(BORROW_FORM)) u_rel (
    .lhs     (lhs_b),
    .rhs     (rhs_a),
    .same    (same_w),
    .below_u (below_u_w),
    .below_s (below_s_w)
  );

  cond_select u_sel (
    .code    (code_w),
    .same    (same_w),
    .below_u (below_u_w),
    .below_s (below_s_w),
    .flag    (cond_true)
  );

  always_comb begin
    if (!$isunknown({lhs_b, rhs_a, cond_sel})) begin
      if (cond_sel == 3'b000)
        p_eq_port_r1: assert (cond_true == (lhs_b == rhs_a));
      if (cond_sel == 3'b001)
        p_ne_port_r2: assert (cond_true == (lhs_b != rhs_a));
      if (cond_sel == 3'b100)
        p_ule_port_r5: assert (cond_true == !(lhs_b > rhs_a));
      if (cond_sel == 3'b111)
        p_sle_port_r8: assert (cond_true == !($signed(lhs_b) > $signed(rhs_a)));
    end
  end
endmodule

// File: tb/cond_cmp_bench.sv
module cond_cmp_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] b8, a8;
  logic [3:0] b4, a4;
  logic [2:0] sel8, sel4;
  logic       y8, y4;

  cond_cmp #(.WIDTH(8), .BORROW_FORM(1'b1)) u_cond_cmp (
    .lhs_b(b8), .rhs_a(a8), .cond_sel(sel8), .cond_true(y8));

  cond_cmp #(.WIDTH(4), .BORROW_FORM(1'b0)) u_cond_cmp_small (
    .lhs_b(b4), .rhs_a(a4), .cond_sel(sel4), .cond_true(y4));

  function automatic string tag_of(int code);
    case (code)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic bit model(int w, int code, int ub, int ua);
    int sb, sa;
    sb = (ub >= (1 << (w - 1))) ? ub - (1 << w) : ub;
    sa = (ua >= (1 << (w - 1))) ? ua - (1 << w) : ua;
    case (code)
      0: return ub == ua;
      1: return ub != ua;
      2: return ub < ua;
      3: return ub > ua;
      4: return ub <= ua;
      5: return sb < sa;
      6: return sb > sa;
      default: return sb <= sa;
    endcase
  endfunction

  task automatic check(string tag, string what, logic got, logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  initial begin
    b8 = '0; a8 = '0; sel8 = 3'b000;
    b4 = '0; a4 = '0; sel4 = 3'b000;
    @(negedge clk);
    // Starting state: equal zero operands under equality (R1)
    check("R1", "start eq 0,0", y8, 1'b1);

    // R10: signed extremes, both orders
    b8 = 8'h80; a8 = 8'h7F;
    sel8 = 3'b101; #1 check("R10", "slt 80<7F", y8, 1'b1);
    sel8 = 3'b010; #1 check("R10", "ult 80<7F", y8, 1'b0);
    sel8 = 3'b011; #1 check("R10", "ugt 80>7F", y8, 1'b1);
    sel8 = 3'b110; #1 check("R10", "sgt 80>7F", y8, 1'b0);
    b8 = 8'h7F; a8 = 8'h80;
    sel8 = 3'b110; #1 check("R10", "sgt 7F>80", y8, 1'b1);
    sel8 = 3'b111; #1 check("R10", "sle 7F<=80", y8, 1'b0);

    // R11: change inputs mid-cycle, flag follows within 1 ns
    @(negedge clk);
    b8 = 8'h05; a8 = 8'h05; sel8 = 3'b000;
    #1 check("R11", "same-cycle eq", y8, 1'b1);
    a8 = 8'h06;
    #1 check("R11", "same-cycle change", y8, 1'b0);

    // R9 + R1..R8: exhaustive sweep, 8-bit borrow form
    for (int c = 0; c < 8; c++) begin
      for (int ub = 0; ub < 256; ub++) begin
        for (int ua = 0; ua < 256; ua++) begin
          sel8 = 3'(c); b8 = 8'(ub); a8 = 8'(ua);
          #1;
          check(tag_of(c), $sformatf("w8 sel=%0d b=%0d a=%0d", c, ub, ua),
                y8, model(8, c, ub, ua));
        end
      end
    end

    // R9 + R1..R8: exhaustive sweep, 4-bit direct form
    for (int c = 0; c < 8; c++) begin
      for (int ub = 0; ub < 16; ub++) begin
        for (int ua = 0; ua < 16; ua++) begin
          sel4 = 3'(c); b4 = 4'(ub); a4 = 4'(ua);
          #1;
          check("R9", $sformatf("w4 %s sel=%0d b=%0d a=%0d", tag_of(c), c, ub, ua),
                y4, model(4, c, ub, ua));
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R11 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule